// File: doc/BRIEF.md
# SD Card Bring-Up Sequencer

This block takes a memory card from power-up to the state in which block transfers can start. It walks a fixed list of commands, and each command goes out on a simple valid/ready issue port as an index, a 32-bit argument and a response kind. Response words come back most significant first on a word port, and the block collects them into a shift register. The operating-conditions query is repeated until the card reports that power-up is complete. The relative card address from the address assignment is kept and used in every later addressed command. The long card-specific-data response is kept on an output register for the geometry logic.

After the block length is set, the sequencer declares the card ready. If the `multi_bank` input is high at that point, it first issues a switch-function command and waits for one 512-byte status block on the data port. A fatal condition parks the sequencer in a failed state. Fatal conditions are an all-zero operating-conditions word, too many busy replies, or a command whose retries run out. A `start` pulse in the idle, ready or failed state begins a new bring-up.

Top module: `sd_card_init`

## Requirements
- R1: After reset, `ready`, `failed` and `cmd_valid` are low and `rca` and `csd` are zero, and no command is issued until `start` is pulsed.
- R2: The first command is index 0 with argument 0 and response kind 0. Kind codes on `cmd_rtype`: 0 none, 1 short 32-bit, 2 long 128-bit, 3 operating-conditions short word.
- R3: The operating-conditions query is index 55 (argument `rca`<<16, kind 1) followed by index 41 with argument 0x00100000 and kind 3.
- R4: An operating-conditions reply equal to zero raises `failed` on the second clock edge after its last word is accepted. No further command follows.
- R5: A nonzero reply with bit 31 clear restarts the sequence at index 0. The OCR_TRIES-th such busy reply raises `failed` instead.
- R6: After a reply with bit 31 set, index 2 (argument 0, kind 2) and then index 3 (argument 0, kind 1) are issued. Bits 31:16 of the index 3 reply appear on `rca`.
- R7: Next come index 9 (argument `rca`<<16, kind 2) and index 7 (argument `rca`<<16, kind 1). The 128-bit index 9 reply, first word most significant, appears on `csd`.
- R8: Next come index 55 (argument `rca`<<16), index 6 with argument (`rca`<<16)|2 and index 16 with argument 512, all kind 1. If `multi_bank` is low when index 16 completes, `ready` rises on the second edge after its last word.
- R9: If `multi_bank` is high then, index 6 with argument 0x80FFFFEF and kind 1 follows. `ready` rises on the edge that accepts the 128th `dat_valid` word (BLOCK_BYTES*8/DATA_W) that arrives after that reply.
- R10: `rsp_err` on a command's reply causes the same command to be reissued. An error on the second half of a prefixed command restarts from its index 55 prefix. When the error follows CMD_RETRIES reissues, `failed` is raised.
- R11: While `cmd_valid` is high and `cmd_ready` low, index, argument and kind hold still. Words on `rsp_valid` or `dat_valid` outside a waiting phase are ignored.
- R12: `start` is ignored while a bring-up is in progress. In the ready or failed state it clears `rca` and `csd` and restarts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up (idle, ready or failed state only) |
| multi_bank | input | 1 | Request the switch-function step before ready |
| cmd_valid | output | 1 | Command presented |
| cmd_ready | input | 1 | Command accepted |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rtype | output | 2 | Response kind code (see R2) |
| rsp_valid | input | 1 | Response word present |
| rsp_word | input | WORD_W (32) | Response word, most significant first |
| rsp_err | input | 1 | Error flag for the reply |
| dat_valid | input | 1 | One status-block data word received |
| rca | output | 16 | Stored relative card address |
| csd | output | 128 | Captured card-specific data |
| ready | output | 1 | Card is ready for transfers |
| failed | output | 1 | Bring-up failed |

## Verification
The sequencer's state shows up first in the index and argument of the next command. A step counter that skipped or repeated a step, or a stale address, shows as a wrong command at the very next handshake, a few cycles after the reply that caused it. Miscounted retries, busy replies or data words appear as `ready` or `failed` changing one edge early or late. That is why the bench compares both flags on every clock against a model that knows exactly when they must change. A wrong word order in the collector shows on `csd` and `rca` once the reply is taken in.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

    localparam logic [31:0] OCR_QUERY_ARG = 32'h0010_0000;
    localparam logic [31:0] SWITCH_ARG    = 32'h80FF_FFEF;
    localparam logic [31:0] BLOCK_LEN_ARG = 32'd512;
    localparam logic [31:0] WIDE_BUS_ARG  = 32'd2;

    typedef enum logic [1:0] {
        RT_NONE  = 2'd0,
        RT_SHORT = 2'd1,
        RT_LONG  = 2'd2,
        RT_OCR   = 2'd3
    } rsp_kind_e;

    // Order is the bring-up order; next_step relies on it.
    typedef enum logic [3:0] {
        ST_GO_IDLE  = 4'd0,
        ST_APP_OCR  = 4'd1,
        ST_OCR      = 4'd2,
        ST_CID      = 4'd3,
        ST_ADDR     = 4'd4,
        ST_CSD      = 4'd5,
        ST_SELECT   = 4'd6,
        ST_APP_BUS  = 4'd7,
        ST_BUS      = 4'd8,
        ST_BLKLEN   = 4'd9,
        ST_SWITCH   = 4'd10
    } step_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ISSUE = 3'd1,
        PH_WAIT  = 3'd2,
        PH_EVAL  = 3'd3,
        PH_DATA  = 3'd4,
        PH_READY = 3'd5,
        PH_FAIL  = 3'd6
    } phase_e;

    typedef struct packed {
        logic [5:0]  index;
        logic [31:0] arg;
        rsp_kind_e   kind;
    } sd_cmd_t;

    function automatic sd_cmd_t cmd_for(step_e s, logic [15:0] rca);
        sd_cmd_t     c;
        logic [31:0] addr_arg;
        addr_arg = {rca, 16'h0000};
        c.index  = 6'd0;
        c.arg    = 32'd0;
        c.kind   = RT_NONE;
        case (s)
            ST_APP_OCR, ST_APP_BUS: begin
                c.index = 6'd55; c.arg = addr_arg; c.kind = RT_SHORT;
            end
            ST_OCR: begin
                c.index = 6'd41; c.arg = OCR_QUERY_ARG; c.kind = RT_OCR;
            end
            ST_CID: begin
                c.index = 6'd2; c.kind = RT_LONG;
            end
            ST_ADDR: begin
                c.index = 6'd3; c.kind = RT_SHORT;
            end
            ST_CSD: begin
                c.index = 6'd9; c.arg = addr_arg; c.kind = RT_LONG;
            end
            ST_SELECT: begin
                c.index = 6'd7; c.arg = addr_arg; c.kind = RT_SHORT;
            end
            ST_BUS: begin
                c.index = 6'd6; c.arg = addr_arg | WIDE_BUS_ARG; c.kind = RT_SHORT;
            end
            ST_BLKLEN: begin
                c.index = 6'd16; c.arg = BLOCK_LEN_ARG; c.kind = RT_SHORT;
            end
            ST_SWITCH: begin
                c.index = 6'd6; c.arg = SWITCH_ARG; c.kind = RT_SHORT;
            end
            default: begin
                c.index = 6'd0;
            end
        endcase
        return c;
    endfunction

    function automatic logic is_prefix(step_e s);
        return (s == ST_APP_OCR) || (s == ST_APP_BUS);
    endfunction

    function automatic logic follows_prefix(step_e s);
        return (s == ST_OCR) || (s == ST_BUS);
    endfunction

    function automatic step_e next_step(step_e s);
        return step_e'(s + 4'd1);
    endfunction

endpackage

// File: rtl/sd_step_counter.sv
module sd_step_counter #(
    parameter int  LIMIT = 4,
    localparam int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_last
);

    logic [CW-1:0] cnt;

    assign at_last = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && !at_last) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R10
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LIMIT - 1));

endmodule

// File: rtl/sd_rsp_collect.sv
module sd_rsp_collect #(
    parameter int  WORD_W    = 32,
    parameter int  MAX_WORDS = 4,
    localparam int CNT_W     = $clog2(MAX_WORDS + 1),
    localparam int ACC_W     = WORD_W * MAX_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              en,
    input  logic [CNT_W-1:0]  need,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    input  logic              word_err,
    output logic              last,
    output logic              err_seen,
    output logic [ACC_W-1:0]  value
);

    logic [CNT_W-1:0] cnt;
    logic             take;
    logic [ACC_W-1:0] shifted;

    assign take = en && word_valid;
    assign last = take && (cnt == need - 1'b1);

    generate
        if (MAX_WORDS > 1) begin : g_shift
            assign shifted = {value[ACC_W-WORD_W-1:0], word};
        end else begin : g_single
            assign shifted = word;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt      <= '0;
            err_seen <= 1'b0;
            value    <= '0;
        end else if (take) begin
            cnt      <= cnt + 1'b1;
            err_seen <= err_seen | word_err;
            value    <= shifted;
        end
    end

    // R11
    words_bound_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt < need));

endmodule

// File: rtl/sd_card_init.sv
module sd_card_init
    import sd_init_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int CMD_RETRIES = 3,
    parameter int OCR_TRIES   = 1000,
    parameter int BLOCK_BYTES = 512,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              multi_bank,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [5:0]        cmd_index,
    output logic [31:0]       cmd_arg,
    output logic [1:0]        cmd_rtype,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_word,
    input  logic              rsp_err,
    input  logic              dat_valid,
    output logic [15:0]       rca,
    output logic [127:0]      csd,
    output logic              ready,
    output logic              failed
);

    localparam int SHORT_WORDS = 32 / WORD_W;
    localparam int LONG_WORDS  = 128 / WORD_W;
    localparam int NEED_W      = $clog2(LONG_WORDS + 1);
    localparam int BLOCK_WORDS = BLOCK_BYTES * 8 / DATA_W;

    phase_e        phase;
    step_e         step;
    logic [15:0]   rca_q;
    logic [127:0]  csd_q;
    sd_cmd_t       cur;

    logic              start_ok;
    logic              eval;
    logic [NEED_W-1:0] need;
    logic              rsp_last;
    logic              rsp_bad;
    logic [127:0]      rsp_value;
    logic [31:0]       short_rsp;
    logic              ocr_busy;
    logic              retry_last;
    logic              ocr_last;
    logic              data_last_word;

    assign cur       = cmd_for(step, rca_q);
    assign cmd_valid = (phase == PH_ISSUE);
    assign cmd_index = cur.index;
    assign cmd_arg   = cur.arg;
    assign cmd_rtype = cur.kind;
    assign rca       = rca_q;
    assign csd       = csd_q;
    assign ready     = (phase == PH_READY);
    assign failed    = (phase == PH_FAIL);

    assign start_ok  = start && (phase == PH_IDLE || phase == PH_READY || phase == PH_FAIL);
    assign eval      = (phase == PH_EVAL);
    assign short_rsp = rsp_value[31:0];
    assign ocr_busy  = eval && !rsp_bad && (step == ST_OCR)
                     && (short_rsp != 32'd0) && !short_rsp[31];

    always_comb begin
        case (cur.kind)
            RT_NONE: need = '0;
            RT_LONG: need = NEED_W'(LONG_WORDS);
            default: need = NEED_W'(SHORT_WORDS);
        endcase
    end

    sd_rsp_collect #(
        .WORD_W    (WORD_W),
        .MAX_WORDS (LONG_WORDS)
    ) u_collect (
        .clk        (clk),
        .rst        (rst),
        .clear      (phase == PH_ISSUE),
        .en         (phase == PH_WAIT),
        .need       (need),
        .word_valid (rsp_valid),
        .word       (rsp_word),
        .word_err   (rsp_err),
        .last       (rsp_last),
        .err_seen   (rsp_bad),
        .value      (rsp_value)
    );

    sd_step_counter #(.LIMIT(CMD_RETRIES + 1)) u_retry (
        .clk     (clk),
        .rst     (rst),
        .clr     (start_ok || (eval && !rsp_bad && !is_prefix(step))),
        .inc     (eval && rsp_bad),
        .at_last (retry_last)
    );

    sd_step_counter #(.LIMIT(OCR_TRIES)) u_ocr (
        .clk     (clk),
        .rst     (rst),
        .clr     (start_ok),
        .inc     (ocr_busy),
        .at_last (ocr_last)
    );

    sd_step_counter #(.LIMIT(BLOCK_WORDS)) u_data (
        .clk     (clk),
        .rst     (rst),
        .clr     (phase != PH_DATA),
        .inc     ((phase == PH_DATA) && dat_valid),
        .at_last (data_last_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            step  <= ST_GO_IDLE;
            rca_q <= '0;
            csd_q <= '0;
        end else begin
            case (phase)
                PH_IDLE, PH_READY, PH_FAIL: begin
                    if (start) begin
                        phase <= PH_ISSUE;
                        step  <= ST_GO_IDLE;
                        rca_q <= '0;
                        csd_q <= '0;
                    end
                end
                PH_ISSUE: begin
                    if (cmd_ready) begin
                        phase <= (cur.kind == RT_NONE) ? PH_EVAL : PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (rsp_last) begin
                        phase <= PH_EVAL;
                    end
                end
                PH_EVAL: begin
                    if (rsp_bad) begin
                        if (retry_last) begin
                            phase <= PH_FAIL;
                        end else begin
                            phase <= PH_ISSUE;
                            if (follows_prefix(step)) begin
                                step <= step_e'(step - 4'd1);
                            end
                        end
                    end else begin
                        case (step)
                            ST_OCR: begin
                                if (short_rsp == 32'd0) begin
                                    phase <= PH_FAIL;
                                end else if (!short_rsp[31]) begin
                                    if (ocr_last) begin
                                        phase <= PH_FAIL;
                                    end else begin
                                        phase <= PH_ISSUE;
                                        step  <= ST_GO_IDLE;
                                    end
                                end else begin
                                    phase <= PH_ISSUE;
                                    step  <= ST_CID;
                                end
                            end
                            ST_ADDR: begin
                                rca_q <= short_rsp[31:16];
                                phase <= PH_ISSUE;
                                step  <= next_step(step);
                            end
                            ST_CSD: begin
                                csd_q <= rsp_value;
                                phase <= PH_ISSUE;
                                step  <= next_step(step);
                            end
                            ST_BLKLEN: begin
                                if (multi_bank) begin
                                    phase <= PH_ISSUE;
                                    step  <= ST_SWITCH;
                                end else begin
                                    phase <= PH_READY;
                                end
                            end
                            ST_SWITCH: begin
                                phase <= PH_DATA;
                            end
                            default: begin
                                phase <= PH_ISSUE;
                                step  <= next_step(step);
                            end
                        endcase
                    end
                end
                PH_DATA: begin
                    if (dat_valid && data_last_word) begin
                        phase <= PH_READY;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_index)
                                  && $stable(cmd_arg) && $stable(cmd_rtype));

    // R6
    rca_source_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rca) |-> $past(start) || ($past(cmd_index) == 6'd3));

    // R7
    csd_source_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(csd) |-> $past(start) || ($past(cmd_index) == 6'd9));

    // R8
    ready_single_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) && !$past(phase == PH_DATA)
            |-> ($past(cmd_index) == 6'd16) && !$past(multi_bank));

    // R9
    ready_block_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) && $past(phase == PH_DATA) |-> $past(dat_valid));

    // R12
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        failed && !start |=> failed);

endmodule

// File: tb/sd_card_init_tb.sv
`timescale 1ns/1ps
module sd_card_init_tb;

    localparam int OCR_LIM = 4;
    localparam logic [1:0] K_NONE  = 2'd0;
    localparam logic [1:0] K_SHORT = 2'd1;
    localparam logic [1:0] K_LONG  = 2'd2;
    localparam logic [1:0] K_OCR   = 2'd3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         multi_bank = 1'b0;
    logic         cmd_valid;
    logic         cmd_ready = 1'b0;
    logic [5:0]   cmd_index;
    logic [31:0]  cmd_arg;
    logic [1:0]   cmd_rtype;
    logic         rsp_valid = 1'b0;
    logic [31:0]  rsp_word = 32'd0;
    logic         rsp_err = 1'b0;
    logic         dat_valid = 1'b0;
    logic [15:0]  rca;
    logic [127:0] csd;
    logic         ready;
    logic         failed;

    int     n_checks = 0;
    int     n_fail = 0;
    bit     done = 1'b0;
    bit     exp_ready = 1'b0;
    bit     exp_failed = 1'b0;
    string  tag = "R1";
    logic [15:0] mdl_rca = 16'h0;

    always #2 clk = ~clk;

    sd_card_init #(.OCR_TRIES(OCR_LIM)) u_dut (
        .clk(clk), .rst(rst), .start(start), .multi_bank(multi_bank),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .cmd_rtype(cmd_rtype), .rsp_valid(rsp_valid),
        .rsp_word(rsp_word), .rsp_err(rsp_err), .dat_valid(dat_valid),
        .rca(rca), .csd(csd), .ready(ready), .failed(failed)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model: status flags compared every clock.
    task automatic tick();
        @(negedge clk);
        check(ready === exp_ready, tag, "ready", ready, exp_ready);
        check(failed === exp_failed, tag, "failed", failed, exp_failed);
    endtask

    task automatic serve(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rt,
                         input logic [127:0] rsp, input bit err, input int delay, input string req);
        int guard;
        int nw;
        guard = 0;
        while (cmd_valid !== 1'b1 && guard < 64) begin
            tick();
            guard++;
        end
        check(cmd_valid === 1'b1, req, "cmd_valid", cmd_valid, 1);
        check(cmd_index === idx, req, "cmd_index", cmd_index, idx);
        check(cmd_arg === arg, req, "cmd_arg", cmd_arg, arg);
        check(cmd_rtype === rt, req, "cmd_rtype", cmd_rtype, rt);
        // stray response words while the command is still pending (R11)
        for (int d = 0; d < delay; d++) begin
            rsp_valid = 1'b1;
            rsp_word  = 32'hDEAD_0000 | d;
            tick();
        end
        rsp_valid = 1'b0;
        cmd_ready = 1'b1;
        tick();
        cmd_ready = 1'b0;
        nw = (rt == K_NONE) ? 0 : ((rt == K_LONG) ? 4 : 1);
        for (int i = 0; i < nw; i++) begin
            rsp_valid = 1'b1;
            rsp_word  = rsp[(nw-1-i)*32 +: 32];
            rsp_err   = err && (i == nw - 1);
            tick();
        end
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
    endtask

    task automatic ocr_round(input logic [31:0] ocr);
        serve(6'd0, 32'd0, K_NONE, 128'd0, 1'b0, 0, "R2");
        serve(6'd55, {mdl_rca, 16'h0}, K_SHORT, 128'h120, 1'b0, 0, "R3");
        serve(6'd41, 32'h0010_0000, K_OCR, {96'd0, ocr}, 1'b0, 1, "R3");
    endtask

    task automatic quiet(input string req);
        for (int k = 0; k < 4; k++) begin
            tick();
            check(cmd_valid === 1'b0, req, "no command after end", cmd_valid, 0);
        end
    endtask

    task automatic restart();
        start = 1'b1;
        exp_ready = 1'b0;
        exp_failed = 1'b0;
        tick();
        start = 1'b0;
        mdl_rca = 16'h0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [127:0] csd_a;
        logic [127:0] csd_b;
        csd_a = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        csd_b = 128'hA5A5_0001_5A5A_0002_C3C3_0003_3C3C_0004;

        repeat (3) tick();
        rst = 1'b0;
        // R1: reset state and idleness without start
        tag = "R1";
        for (int k = 0; k < 4; k++) begin
            tick();
            check(cmd_valid === 1'b0, "R1", "cmd_valid idle", cmd_valid, 0);
        end
        check(rca === 16'h0, "R1", "rca reset", rca, 0);
        check(csd === 128'h0, "R1", "csd reset", csd, 0);

        // Single-bank bring-up with a busy loop, retries and stray words
        tag = "R8";
        restart();
        ocr_round(32'h00FF_8000);                       // R5 busy -> restart
        ocr_round(32'h80FF_8000);
        serve(6'd2, 32'd0, K_LONG, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 1'b0, 0, "R6");
        serve(6'd3, 32'd0, K_SHORT, 128'hABCD_0500, 1'b1, 0, "R10");
        serve(6'd3, 32'd0, K_SHORT, 128'hABCD_0500, 1'b1, 0, "R10");
        serve(6'd3, 32'd0, K_SHORT, 128'hABCD_0500, 1'b0, 0, "R6");
        mdl_rca = 16'hABCD;
        serve(6'd9, {mdl_rca, 16'h0}, K_LONG, csd_a, 1'b0, 3, "R7");
        check(rca === 16'hABCD, "R6", "rca from reply bits 31:16", rca, 16'hABCD);
        start = 1'b1;                                    // R12 ignored while busy
        tick();
        start = 1'b0;
        check(csd === csd_a, "R7", "csd capture", csd, csd_a);
        serve(6'd7, {mdl_rca, 16'h0}, K_SHORT, 128'h700, 1'b0, 0, "R7");
        tick();
        start = 1'b1;
        tick();
        start = 1'b0;
        serve(6'd55, {mdl_rca, 16'h0}, K_SHORT, 128'h920, 1'b0, 0, "R12");
        serve(6'd6, {mdl_rca, 16'h2}, K_SHORT, 128'h900, 1'b1, 0, "R10");
        serve(6'd55, {mdl_rca, 16'h0}, K_SHORT, 128'h920, 1'b0, 0, "R10");
        serve(6'd6, {mdl_rca, 16'h2}, K_SHORT, 128'h900, 1'b0, 0, "R8");
        serve(6'd16, 32'd512, K_SHORT, 128'h900, 1'b0, 2, "R8");
        exp_ready = 1'b1;
        tick();
        quiet("R8");

        // Restart from ready, multi-bank path with status block
        multi_bank = 1'b1;
        tag = "R12";
        restart();
        check(rca === 16'h0, "R12", "rca cleared by start", rca, 0);
        check(csd === 128'h0, "R12", "csd cleared by start", csd, 0);
        tag = "R9";
        ocr_round(32'h80FF_8000);
        serve(6'd2, 32'd0, K_LONG, 128'h9, 1'b0, 0, "R6");
        serve(6'd3, 32'd0, K_SHORT, 128'h1234_0000, 1'b0, 0, "R6");
        mdl_rca = 16'h1234;
        serve(6'd9, {mdl_rca, 16'h0}, K_LONG, csd_b, 1'b0, 0, "R7");
        serve(6'd7, {mdl_rca, 16'h0}, K_SHORT, 128'h700, 1'b0, 0, "R7");
        serve(6'd55, {mdl_rca, 16'h0}, K_SHORT, 128'h920, 1'b0, 0, "R8");
        serve(6'd6, {mdl_rca, 16'h2}, K_SHORT, 128'h900, 1'b0, 0, "R8");
        serve(6'd16, 32'd512, K_SHORT, 128'h900, 1'b0, 0, "R8");
        serve(6'd6, 32'h80FF_FFEF, K_SHORT, 128'h900, 1'b0, 0, "R9");
        dat_valid = 1'b1;                                // R11 stray word before data phase
        tick();
        for (int i = 0; i < 128; i++) begin
            if (i % 40 == 7) begin
                dat_valid = 1'b0;
                tick();
            end
            dat_valid = 1'b1;
            if (i == 127) exp_ready = 1'b1;
            tick();
        end
        dat_valid = 1'b0;
        check(csd === csd_b, "R7", "csd capture second run", csd, csd_b);
        check(rca === 16'h1234, "R6", "rca second run", rca, 16'h1234);
        quiet("R9");

        // All-zero OCR
        multi_bank = 1'b0;
        tag = "R4";
        restart();
        serve(6'd0, 32'd0, K_NONE, 128'd0, 1'b0, 0, "R2");
        serve(6'd55, 32'd0, K_SHORT, 128'h120, 1'b0, 0, "R3");
        serve(6'd41, 32'h0010_0000, K_OCR, 128'd0, 1'b0, 0, "R4");
        exp_failed = 1'b1;
        tick();
        quiet("R4");

        // Busy-reply limit
        tag = "R5";
        restart();
        for (int k = 0; k < OCR_LIM; k++) begin
            ocr_round(32'h0000_8000);
        end
        exp_failed = 1'b1;
        tick();
        quiet("R5");

        // Retry exhaustion
        tag = "R10";
        restart();
        ocr_round(32'h80FF_8000);
        for (int k = 0; k < 4; k++) begin
            serve(6'd2, 32'd0, K_LONG, 128'h5, 1'b1, 0, "R10");
        end
        exp_failed = 1'b1;
        tick();
        quiet("R10");

        done = 1'b1;
        finish_run();
    end

endmodule